// File: doc/BRIEF.md
# Three-Way Exponent Maximum Selector

This unit sits in front of a floating-point multiply-accumulate alignment stage. It receives three exponents: the exponent sums of two products and the exponent of the addend. It reports which of the three is largest, what that largest exponent is, and how far right each term's mantissa must be shifted to line up with it. Each input also carries a zero flag. A flagged term takes part as the smallest possible value, so it never sets the reference exponent.

The three pairwise differences are formed side by side. Only their three borrow (sign) bits go into a small decode table, and that table selects the winner. The result is registered once, so every request takes exactly one cycle, whatever values arrive. Each shift amount is the reference exponent minus the term's own exponent. It is limited to the mantissa datapath width, because any larger gap would already push the term completely out of the shifter.

Top module: `exp_max3_sel`

## Requirements
- R1: While reset is held and on the first edge after it, `out_valid` is 0, `max_exp` is 0, `win_sel` is 3'b000 and all three shift outputs are 0.
- R2: `max_exp` equals the largest exponent among the terms whose zero flag is clear. It is 0 when all three flags are set.
- R3: `win_sel` is one-hot with bit 0 for term A, bit 1 for B and bit 2 for C. It marks the largest term. On equal exponents the lowest bit index wins.
- R4: A term with its zero flag set is never marked in `win_sel` unless all three flags are set. In that case term A (bit 0) is marked.
- R5: Each shift output equals `max_exp` minus that term's exponent, where a zero-flagged term counts as exponent 0. Any value above MW is replaced by MW, so the winning term always shifts by 0.
- R6: Results appear exactly one clock after `in_valid` is sampled high, and `out_valid` is `in_valid` delayed by one cycle.
- R7: When `in_valid` is low, `max_exp`, `win_sel` and the three shift outputs keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| exp_a | input | EW | Exponent of product term A |
| exp_b | input | EW | Exponent of product term B |
| exp_c | input | EW | Exponent of addend term C |
| zero_a | input | 1 | Term A is zero |
| zero_b | input | 1 | Term B is zero |
| zero_c | input | 1 | Term C is zero |
| out_valid | output | 1 | Outputs hold a new result |
| max_exp | output | EW | Reference (largest) exponent |
| win_sel | output | 3 | One-hot winner: bit0 A, bit1 B, bit2 C |
| sh_a | output | $clog2(MW+1) | Alignment shift for A |
| sh_b | output | $clog2(MW+1) | Alignment shift for B |
| sh_c | output | $clog2(MW+1) | Alignment shift for C |

## Verification
The bench builds the unit with EW=4 and MW=5. With these values, every combination of three exponents and three zero flags fits in 32768 vectors, so the bench applies all of them. Exponent gaps run up to 15, which is well past the clamp of 5, so both clamped and unclamped shifts are covered. All tie patterns are covered, and so is every mix of zero flags, including all three set. Hold behaviour and one-cycle latency are checked on top of the full sweep.

// File: rtl/exp_max3_sel.sv
module exp_max3_sel #(
  parameter int EW = 7,
  parameter int MW = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [EW-1:0]              exp_a,
  input  logic [EW-1:0]              exp_b,
  input  logic [EW-1:0]              exp_c,
  input  logic                       zero_a,
  input  logic                       zero_b,
  input  logic                       zero_c,
  output logic                       out_valid,
  output logic [EW-1:0]              max_exp,
  output logic [2:0]                 win_sel,
  output logic [$clog2(MW+1)-1:0]    sh_a,
  output logic [$clog2(MW+1)-1:0]    sh_b,
  output logic [$clog2(MW+1)-1:0]    sh_c
);
  localparam int KW = EW + 1;
  localparam int SW = $clog2(MW + 1);

  wire [EW-1:0] ea = zero_a ? {EW{1'b0}} : exp_a;
  wire [EW-1:0] eb = zero_b ? {EW{1'b0}} : exp_b;
  wire [EW-1:0] ec = zero_c ? {EW{1'b0}} : exp_c;

  wire [KW-1:0] ka = {~zero_a, ea};
  wire [KW-1:0] kb = {~zero_b, eb};
  wire [KW-1:0] kc = {~zero_c, ec};

  wire [KW:0] d_ab = {1'b0, ka} - {1'b0, kb};
  wire [KW:0] d_ac = {1'b0, ka} - {1'b0, kc};
  wire [KW:0] d_bc = {1'b0, kb} - {1'b0, kc};

  wire [2:0] idx = {d_ab[KW], d_ac[KW], d_bc[KW]};

  logic [2:0]    win;
  logic [EW-1:0] emax;

  always_comb begin
    case (idx)
      3'b000, 3'b001: win = 3'b001;
      3'b100, 3'b110: win = 3'b010;
      default:        win = 3'b100;
    endcase
    case (win)
      3'b001:  emax = ea;
      3'b010:  emax = eb;
      default: emax = ec;
    endcase
  end

  function automatic logic [SW-1:0] clamp_sh(input logic [EW-1:0] m, input logic [EW-1:0] e);
    logic [EW-1:0] d;
    d = m - e;
    if (int'(d) > MW) return SW'(MW);
    return SW'(d);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      max_exp   <= '0;
      win_sel   <= '0;
      sh_a      <= '0;
      sh_b      <= '0;
      sh_c      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        max_exp <= emax;
        win_sel <= win;
        sh_a    <= clamp_sh(emax, ea);
        sh_b    <= clamp_sh(emax, eb);
        sh_c    <= clamp_sh(emax, ec);
      end
    end
  end

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(win_sel));

  a_r5_winner_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((win_sel[0] -> sh_a == 0) && (win_sel[1] -> sh_b == 0) && (win_sel[2] -> sh_c == 0)));

  a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(sh_a) <= MW && int'(sh_b) <= MW && int'(sh_c) <= MW));

  a_r4_zero_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_a && !(zero_b && zero_c)) |=> !win_sel[0]);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(max_exp) && $stable(win_sel) && $stable(sh_a) && $stable(sh_b) && $stable(sh_c)));
endmodule

// File: tb/tb_exp_max3_sel.sv
module tb_exp_max3_sel;
  localparam int EW = 4;
  localparam int MW = 5;
  localparam int SW = $clog2(MW + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [EW-1:0] exp_a = 0, exp_b = 0, exp_c = 0;
  logic zero_a = 0, zero_b = 0, zero_c = 0;
  logic out_valid;
  logic [EW-1:0] max_exp;
  logic [2:0] win_sel;
  logic [SW-1:0] sh_a, sh_b, sh_c;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  exp_max3_sel #(.EW(EW), .MW(MW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .exp_a(exp_a), .exp_b(exp_b), .exp_c(exp_c),
    .zero_a(zero_a), .zero_b(zero_b), .zero_c(zero_c),
    .out_valid(out_valid), .max_exp(max_exp), .win_sel(win_sel),
    .sh_a(sh_a), .sh_b(sh_b), .sh_c(sh_c)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int d);
    return (d > MW) ? MW : d;
  endfunction

  task automatic run_vec(input int a, input int b, input int c, input int z);
    int va, vb, vc, ka, kb, kc, m, w;
    @(negedge clk);
    in_valid = 1;
    exp_a = EW'(a); exp_b = EW'(b); exp_c = EW'(c);
    zero_a = z[0]; zero_b = z[1]; zero_c = z[2];
    va = z[0] ? 0 : a; vb = z[1] ? 0 : b; vc = z[2] ? 0 : c;
    ka = z[0] ? 0 : 16 + a; kb = z[1] ? 0 : 16 + b; kc = z[2] ? 0 : 16 + c;
    w = 1; m = va;
    if (kb > ka) begin w = 2; m = vb; end
    if (kc > ka && kc > kb) begin w = 4; m = vc; end
    @(negedge clk);
    chk("R6 out_valid", int'(out_valid), 1);
    chk("R2 max_exp", int'(max_exp), m);
    chk("R3/R4 win_sel", int'(win_sel), w);
    chk("R5 sh_a", int'(sh_a), clampv(m - va));
    chk("R5 sh_b", int'(sh_b), clampv(m - vb));
    chk("R5 sh_c", int'(sh_c), clampv(m - vc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 max_exp", int'(max_exp), 0);
    chk("R1 win_sel", int'(win_sel), 0);
    chk("R1 shifts", int'(sh_a) + int'(sh_b) + int'(sh_c), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R6 idle out_valid", int'(out_valid), 0);

    for (int z = 0; z < 8; z++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 16; c++)
            run_vec(a, b, c, z);

    // R7 hold: known result, then changed inputs with in_valid low
    run_vec(9, 3, 12, 0);
    @(negedge clk);
    in_valid = 0;
    exp_a = 15; exp_b = 0; exp_c = 1; zero_a = 0; zero_b = 1; zero_c = 0;
    @(negedge clk);
    chk("R6 out_valid low", int'(out_valid), 0);
    chk("R7 max_exp held", int'(max_exp), 12);
    chk("R7 win_sel held", int'(win_sel), 4);
    chk("R7 sh_a held", int'(sh_a), 3);
    chk("R7 sh_b held", int'(sh_b), 5);
    chk("R7 sh_c held", int'(sh_c), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule